// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block is the master side of a handshake-timed parallel bus. A requester presents one transfer: an address, a direction, byte-lane enables, a function code and, for writes, the data. The block then runs the bus cycle. It drives the address and an active-low address strobe, then active-low upper and lower data strobes for the selected byte lanes. It waits as many clocks as the slave needs, and it reports exactly one outcome back: normal completion with read data, or a bus-error trap. When the slave asks for a retry, it gives a retry notice and then runs the same cycle again.

The cycle has no fixed length. The slave ends it with an acknowledge, with bus error alone, or with bus error and halt together. A late-verification mode keeps the cycle open for one extra clock after the acknowledge, so that a slave can still raise bus error when its data turns out bad. A timeout counter raises a hang flag for test use only and does not affect the cycle.

Top module: `async_bus_master`

## Requirements
- R1: While reset is held and after it is released, the address strobe and both data strobes are high (negated), read/write is high, the data bus is not driven, req_ready_o is 1 and rsp_done_o, rsp_berr_o, rsp_retry_o and hang_o are 0.
- R2: A request is accepted on a clock where req_valid_i and req_ready_o are 1 and the bus acknowledge and bus error inputs are negated. From the next clock, bus_as_no is 0 and bus_addr_o and bus_fc_o carry the request. bus_rw_o is 1 for a read and 0 for a write. req_be_i bit 1 selects bus_uds_no and bit 0 selects bus_lds_no. A read asserts its data strobes in the same clock as the address strobe. A write drives bus_data_o (bus_data_oe_o = 1) from that clock and asserts its data strobes one clock later.
- R3: The block samples acknowledge, bus error and halt on every clock edge from the second edge after acceptance, and holds the cycle open without limit. If the acknowledge is first asserted before edge S = max(2, W+1), counted from the acceptance edge as edge 0 (W = slave wait), then in normal mode rsp_done_o pulses for one clock after edge S.
- R4: On a read, the data bus is captured on the edge that accepts the cycle and is presented on rsp_rdata_o while rsp_done_o is 1.
- R5: Bus error asserted without halt ends the cycle with a one-clock rsp_berr_o pulse and no rsp_done_o.
- R6: Bus error and halt asserted together give a one-clock rsp_retry_o pulse and negate the strobes. The block waits until acknowledge, bus error and halt are all negated, then reruns the cycle with the same address, function code, direction, lanes and write data.
- R7: With late_verify_i = 1, an acknowledge keeps the strobes asserted for one more clock, and the result is taken on the next edge. If bus error is then negated, rsp_done_o pulses one clock later than in R3. Bus error alone gives a trap, and bus error with halt gives a retry.
- R8: The strobes are negated in the clock in which the outcome pulse is given. req_ready_o returns to 1, and a new address strobe can begin, only after the slave has negated acknowledge and bus error.
- R9: When the cycle has waited 16 clocks (parameter TIMEOUT) in its sampling phase with no termination, hang_o is 1 while the strobes stay asserted, and the cycle still ends only on a slave response.
- R10: When acknowledge and bus error are asserted on the same clock, bus error wins and the outcome is a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| late_verify_i | input | 1 | 1: keep sampling bus error for one clock after the acknowledge |
| req_valid_i | input | 1 | Transfer request |
| req_ready_o | output | 1 | Sequencer idle, request can be accepted |
| req_addr_i | input | ADDR_W (23) | Transfer address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | DATA_W/8 (2) | Byte-lane enables, bit 1 upper, bit 0 lower |
| req_fc_i | input | FC_W (3) | Function code for the cycle |
| req_wdata_i | input | DATA_W (16) | Write data |
| rsp_done_o | output | 1 | One-clock pulse: normal completion |
| rsp_berr_o | output | 1 | One-clock pulse: bus-error trap |
| rsp_retry_o | output | 1 | One-clock pulse: cycle will be rerun |
| rsp_rdata_o | output | DATA_W (16) | Captured read data |
| hang_o | output | 1 | Timeout observed, test use only |
| bus_addr_o | output | ADDR_W (23) | Bus address |
| bus_fc_o | output | FC_W (3) | Bus function code |
| bus_as_no | output | 1 | Address strobe, active low |
| bus_rw_o | output | 1 | 1 = read, 0 = write |
| bus_uds_no | output | 1 | Upper data strobe, active low |
| bus_lds_no | output | 1 | Lower data strobe, active low |
| bus_data_o | output | DATA_W (16) | Write data to the bus |
| bus_data_oe_o | output | 1 | Drive enable for bus_data_o |
| bus_data_i | input | DATA_W (16) | Read data from the bus |
| bus_dtack_ni | input | 1 | Transfer acknowledge, active low |
| bus_berr_ni | input | 1 | Bus error, active low |
| bus_halt_ni | input | 1 | Halt, active low |

## Verification
The bench measures the outcome edge against a slave model with 0 to 5 wait clocks. A sequencer that sampled too early, or that ignored waits, reports completion on the wrong edge. In late-verification mode it raises bus error one clock after the acknowledge. A design without the extra sampling clock would then report completion instead of a trap or a retry. Acknowledge and bus error are asserted together to show that error takes priority. A slave that holds the acknowledge after the strobes drop shows whether the next cycle could start too early. Retries are counted and each rerun's address is compared, to catch a rerun that was lost or altered.

// File: rtl/abm_pkg.sv
package abm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STROBE,
    ST_VERIFY,
    ST_RELEASE,
    ST_RERUN
  } abm_state_e;

  typedef enum logic [1:0] {
    TERM_NONE,
    TERM_ACK,
    TERM_TRAP,
    TERM_RERUN
  } abm_term_e;
endpackage

// File: rtl/abm_term_decode.sv
module abm_term_decode
  import abm_pkg::*;
(
  input  logic      dtack_ni,
  input  logic      berr_ni,
  input  logic      halt_ni,
  output abm_term_e term_o
);
  // error outranks acknowledge; error with halt asks for a rerun
  always_comb begin
    if (!berr_ni && !halt_ni)  term_o = TERM_RERUN;
    else if (!berr_ni)         term_o = TERM_TRAP;
    else if (!dtack_ni)        term_o = TERM_ACK;
    else                       term_o = TERM_NONE;
  end
endmodule

// File: rtl/abm_wait_timer.sv
module abm_wait_timer #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic hang_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!en_i)                   cnt_q <= '0;
    else if (cnt_q != CW'(TIMEOUT))   cnt_q <= cnt_q + 1'b1;
  end

  assign hang_o = en_i && (cnt_q == CW'(TIMEOUT));
endmodule

// File: rtl/abm_req_regs.sv
module abm_req_regs #(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FC_W   = 3,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [LANES-1:0]  be_o,
  output logic [FC_W-1:0]   fc_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      write_o <= 1'b0;
      be_o    <= '0;
      fc_o    <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      write_o <= write_i;
      be_o    <= be_i;
      fc_o    <= fc_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= bus_data_i;
  end
endmodule

// File: rtl/abm_seq_fsm.sv
module abm_seq_fsm
  import abm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       late_i,
  input  abm_term_e  term_i,
  input  logic       dtack_ni,
  input  logic       berr_ni,
  input  logic       halt_ni,
  output abm_state_e state_o,
  output logic       load_o,
  output logic       cap_o,
  output logic       done_o,
  output logic       trap_o,
  output logic       retry_o
);
  abm_state_e state_q, state_d;
  logic done_d, trap_d, retry_d;
  logic lines_free;

  assign lines_free = dtack_ni && berr_ni;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    cap_o   = 1'b0;
    done_d  = 1'b0;
    trap_d  = 1'b0;
    retry_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i && lines_free) begin
          load_o  = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: state_d = ST_STROBE;
      ST_STROBE: begin
        unique case (term_i)
          TERM_RERUN: begin retry_d = 1'b1; state_d = ST_RERUN; end
          TERM_TRAP:  begin trap_d = 1'b1; state_d = ST_RELEASE; end
          TERM_ACK: begin
            if (late_i) state_d = ST_VERIFY;
            else begin
              cap_o   = 1'b1;
              done_d  = 1'b1;
              state_d = ST_RELEASE;
            end
          end
          default: ; // wait state
        endcase
      end
      ST_VERIFY: begin
        unique case (term_i)
          TERM_RERUN: begin retry_d = 1'b1; state_d = ST_RERUN; end
          TERM_TRAP:  begin trap_d = 1'b1; state_d = ST_RELEASE; end
          default: begin
            cap_o   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_RELEASE;
          end
        endcase
      end
      ST_RELEASE: if (lines_free) state_d = ST_IDLE;
      ST_RERUN:   if (lines_free && halt_ni) state_d = ST_ADDR;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      trap_o  <= 1'b0;
      retry_o <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      trap_o  <= trap_d;
      retry_o <= retry_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/async_bus_master.sv
module async_bus_master
  import abm_pkg::*;
#(
  parameter int unsigned ADDR_W  = 23,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned FC_W    = 3,
  parameter int unsigned TIMEOUT = 16,
  localparam int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              late_verify_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [LANES-1:0]  req_be_i,
  input  logic [FC_W-1:0]   req_fc_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_done_o,
  output logic              rsp_berr_o,
  output logic              rsp_retry_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              hang_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [FC_W-1:0]   bus_fc_o,
  output logic              bus_as_no,
  output logic              bus_rw_o,
  output logic              bus_uds_no,
  output logic              bus_lds_no,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_dtack_ni,
  input  logic              bus_berr_ni,
  input  logic              bus_halt_ni
);
  abm_state_e        state;
  abm_term_e         term;
  logic              load, cap;
  logic              wr_q;
  logic [LANES-1:0]  be_q;
  logic              cyc_active, ds_active;
  logic [LANES-1:0]  lane_n;

  abm_term_decode u_term (
    .dtack_ni (bus_dtack_ni),
    .berr_ni  (bus_berr_ni),
    .halt_ni  (bus_halt_ni),
    .term_o   (term)
  );

  abm_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .late_i      (late_verify_i),
    .term_i      (term),
    .dtack_ni    (bus_dtack_ni),
    .berr_ni     (bus_berr_ni),
    .halt_ni     (bus_halt_ni),
    .state_o     (state),
    .load_o      (load),
    .cap_o       (cap),
    .done_o      (rsp_done_o),
    .trap_o      (rsp_berr_o),
    .retry_o     (rsp_retry_o)
  );

  abm_req_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FC_W   (FC_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .addr_i     (req_addr_i),
    .write_i    (req_write_i),
    .be_i       (req_be_i),
    .fc_i       (req_fc_i),
    .wdata_i    (req_wdata_i),
    .cap_i      (cap),
    .bus_data_i (bus_data_i),
    .addr_o     (bus_addr_o),
    .write_o    (wr_q),
    .be_o       (be_q),
    .fc_o       (bus_fc_o),
    .wdata_o    (bus_data_o),
    .rdata_o    (rsp_rdata_o)
  );

  abm_wait_timer #(
    .TIMEOUT (TIMEOUT)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state == ST_STROBE),
    .hang_o (hang_o)
  );

  assign cyc_active = (state == ST_ADDR) || (state == ST_STROBE) || (state == ST_VERIFY);
  // write strobes trail the address strobe by one clock so data is settled
  assign ds_active  = ((state == ST_ADDR) && !wr_q) || (state == ST_STROBE) ||
                      (state == ST_VERIFY);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g] = !(ds_active && be_q[g]);
  end

  assign bus_as_no     = !cyc_active;
  assign bus_uds_no    = lane_n[LANES-1];
  assign bus_lds_no    = lane_n[0];
  assign bus_rw_o      = !(cyc_active && wr_q);
  assign bus_data_oe_o = cyc_active && wr_q;
  assign req_ready_o   = (state == ST_IDLE);
endmodule

// File: rtl/abm_checker.sv
module abm_checker #(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned FC_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_done_o,
  input logic              rsp_berr_o,
  input logic              rsp_retry_o,
  input logic              hang_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [FC_W-1:0]   bus_fc_o,
  input logic              bus_as_no,
  input logic              bus_rw_o,
  input logic              bus_uds_no,
  input logic              bus_lds_no,
  input logic              bus_data_oe_o,
  input logic              bus_dtack_ni,
  input logic              bus_berr_ni
);
  assert_ds_inside_as_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_uds_no || !bus_lds_no) |-> !bus_as_no)
    else $error("data strobe outside address strobe");

  assert_wdata_driven_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_as_no && !bus_rw_o) |-> bus_data_oe_o)
    else $error("write cycle without data drive");

  assert_done_from_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> $past(!bus_as_no))
    else $error("completion without an open cycle");

  assert_one_outcome_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_done_o, rsp_berr_o, rsp_retry_o}))
    else $error("more than one outcome pulse");

  assert_trap_from_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_berr_o |-> $past(!bus_as_no))
    else $error("trap without an open cycle");

  assert_retry_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_retry_o |-> (bus_as_no && bus_uds_no && bus_lds_no))
    else $error("strobes held during retry");

  assert_request_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> ($stable(bus_addr_o) && $stable(bus_fc_o)))
    else $error("address changed inside a transfer");

  assert_end_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o || rsp_berr_o) |-> (bus_as_no && bus_uds_no && bus_lds_no))
    else $error("strobes held after outcome");

  assert_start_after_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_as_no) |-> ($past(bus_dtack_ni) && $past(bus_berr_ni)))
    else $error("cycle started while slave still responding");

  assert_hang_keeps_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hang_o) |-> !bus_as_no)
    else $error("hang flagged outside a cycle");
endmodule

bind async_bus_master abm_checker #(
  .ADDR_W (ADDR_W),
  .FC_W   (FC_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_ready_o   (req_ready_o),
  .rsp_done_o    (rsp_done_o),
  .rsp_berr_o    (rsp_berr_o),
  .rsp_retry_o   (rsp_retry_o),
  .hang_o        (hang_o),
  .bus_addr_o    (bus_addr_o),
  .bus_fc_o      (bus_fc_o),
  .bus_as_no     (bus_as_no),
  .bus_rw_o      (bus_rw_o),
  .bus_uds_no    (bus_uds_no),
  .bus_lds_no    (bus_lds_no),
  .bus_data_oe_o (bus_data_oe_o),
  .bus_dtack_ni  (bus_dtack_ni),
  .bus_berr_ni   (bus_berr_ni)
);

// File: tb/async_bus_master_bench.sv
`timescale 1ns/1ps
module async_bus_master_bench;
  localparam int TB_TO = 16;
  localparam logic [2:0] K_ACK = 3'd0, K_BERR = 3'd1, K_RERUN = 3'd2, K_LATE_BERR = 3'd3,
                         K_BOTH = 3'd4, K_LATE_RERUN = 3'd5, K_HOLD = 3'd6, K_HANG = 3'd7;

  typedef struct packed {
    logic        wr;
    logic [1:0]  be;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [2:0]  fc;
    logic [3:0]  wt;
    logic [2:0]  kind;
    logic        late;
    logic        res;    // 0 done, 1 trap
    logic [5:0]  lat;    // 0 = not checked
    logic [1:0]  retry;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b11, 8'h12, 16'h0000, 3'd5, 4'd0, K_ACK,        1'b0, 1'b0, 6'd2, 2'd0},
    '{1'b1, 2'b11, 8'h34, 16'hA5C3, 3'd1, 4'd2, K_ACK,        1'b0, 1'b0, 6'd3, 2'd0},
    '{1'b1, 2'b10, 8'h56, 16'h1234, 3'd1, 4'd1, K_ACK,        1'b0, 1'b0, 6'd2, 2'd0},
    '{1'b0, 2'b01, 8'h78, 16'h0000, 3'd6, 4'd5, K_ACK,        1'b0, 1'b0, 6'd6, 2'd0},
    '{1'b0, 2'b11, 8'h9A, 16'h0000, 3'd5, 4'd3, K_BERR,       1'b0, 1'b1, 6'd4, 2'd0},
    '{1'b1, 2'b11, 8'hBC, 16'h0F0F, 3'd1, 4'd1, K_RERUN,      1'b0, 1'b0, 6'd0, 2'd1},
    '{1'b0, 2'b11, 8'hDE, 16'h0000, 3'd6, 4'd2, K_ACK,        1'b1, 1'b0, 6'd4, 2'd0},
    '{1'b0, 2'b11, 8'hF0, 16'h0000, 3'd5, 4'd2, K_LATE_BERR,  1'b1, 1'b1, 6'd4, 2'd0},
    '{1'b0, 2'b11, 8'h21, 16'h0000, 3'd5, 4'd1, K_BOTH,       1'b0, 1'b1, 6'd2, 2'd0},
    '{1'b0, 2'b11, 8'h43, 16'h0000, 3'd6, 4'd2, K_LATE_RERUN, 1'b1, 1'b0, 6'd0, 2'd1},
    '{1'b0, 2'b11, 8'h65, 16'h0000, 3'd5, 4'd0, K_HOLD,       1'b0, 1'b0, 6'd2, 2'd0},
    '{1'b1, 2'b01, 8'h87, 16'hBEEF, 3'd1, 4'd4, K_ACK,        1'b1, 1'b0, 6'd6, 2'd0}
  };
  localparam vec_t HANG_VEC =
    '{1'b0, 2'b11, 8'hA9, 16'h0000, 3'd5, 4'd0, K_HANG, 1'b0, 1'b1, 6'(TB_TO + 4), 2'd0};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        late_verify_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [22:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_be_i = '0;
  logic [2:0]  req_fc_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        rsp_done_o, rsp_berr_o, rsp_retry_o, hang_o;
  logic [15:0] rsp_rdata_o;
  logic [22:0] bus_addr_o;
  logic [2:0]  bus_fc_o;
  logic        bus_as_no, bus_rw_o, bus_uds_no, bus_lds_no, bus_data_oe_o;
  logic [15:0] bus_data_o, bus_data_i;
  logic        bus_dtack_ni = 1'b1, bus_berr_ni = 1'b1, bus_halt_ni = 1'b1;

  async_bus_master #(.TIMEOUT(TB_TO)) u_async_bus_master (
    .clk_i, .rst_ni, .late_verify_i, .req_valid_i, .req_ready_o, .req_addr_i,
    .req_write_i, .req_be_i, .req_fc_i, .req_wdata_i, .rsp_done_o, .rsp_berr_o,
    .rsp_retry_o, .rsp_rdata_o, .hang_o, .bus_addr_o, .bus_fc_o, .bus_as_no,
    .bus_rw_o, .bus_uds_no, .bus_lds_no, .bus_data_o, .bus_data_oe_o, .bus_data_i,
    .bus_dtack_ni, .bus_berr_ni, .bus_halt_ni
  );

  always #5 clk_i = ~clk_i;

  assign bus_data_i = bus_rw_o ? {bus_addr_o[7:0], ~bus_addr_o[7:0]} : 16'h0000;

  int   checks = 0, failures = 0;
  bit   finished = 0;
  vec_t cur;
  int   cnt, attempt, hold, as_falls, retries;
  bit   in_cyc, addr_bad, ds_first, overlap, early_ready, hang_seen, hang_as_bad;
  logic [1:0]  lanes_seen;
  logic [15:0] cap_data;

  function automatic logic [22:0] full_addr(input logic [7:0] a);
    return {15'h2C1, a};
  endfunction

  // slave model, acts on the falling edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rsp_retry_o) retries++;
      if (hang_o) begin
        hang_seen = 1;
        if (bus_as_no) hang_as_bad = 1;
      end
      if (req_ready_o && !bus_dtack_ni) early_ready = 1;
      if (!bus_as_no) begin
        if (!in_cyc) begin
          in_cyc = 1;
          as_falls++;
          cnt = 0;
          if (!bus_dtack_ni || !bus_berr_ni) overlap = 1;
          if (bus_addr_o != full_addr(cur.addr) || bus_rw_o != !cur.wr || bus_fc_o != cur.fc)
            addr_bad = 1;
          if (attempt == 0) ds_first = !bus_uds_no || !bus_lds_no;
        end
        lanes_seen |= {!bus_uds_no, !bus_lds_no};
        if (!bus_rw_o) begin
          if (!bus_uds_no) cap_data[15:8] = bus_data_o[15:8];
          if (!bus_lds_no) cap_data[7:0]  = bus_data_o[7:0];
        end
        if (cur.kind == K_HANG) begin
          if (cnt == TB_TO + 3) bus_berr_ni = 1'b0;
        end else if (cnt == int'(cur.wt)) begin
          if (attempt > 0) bus_dtack_ni = 1'b0;
          else case (cur.kind)
            K_BERR:  bus_berr_ni = 1'b0;
            K_RERUN: begin bus_berr_ni = 1'b0; bus_halt_ni = 1'b0; end
            K_BOTH:  begin bus_dtack_ni = 1'b0; bus_berr_ni = 1'b0; end
            default: bus_dtack_ni = 1'b0;
          endcase
        end else if (cnt == int'(cur.wt) + 1 && attempt == 0) begin
          if (cur.kind == K_LATE_BERR) bus_berr_ni = 1'b0;
          if (cur.kind == K_LATE_RERUN) begin bus_berr_ni = 1'b0; bus_halt_ni = 1'b0; end
        end
        cnt++;
      end else begin
        if (in_cyc) begin
          in_cyc = 0;
          attempt++;
          hold = (cur.kind == K_HOLD) ? 3 :
                 ((cur.kind == K_RERUN || cur.kind == K_LATE_RERUN) ? 2 : 0);
        end
        if (hold > 0) hold--;
        else begin
          bus_dtack_ni = 1'b1;
          bus_berr_ni  = 1'b1;
          bus_halt_ni  = 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    case (v.kind)
      K_BERR:       return "R5";
      K_RERUN:      return "R6";
      K_LATE_BERR:  return "R7";
      K_LATE_RERUN: return "R7";
      K_BOTH:       return "R10";
      K_HOLD:       return "R8";
      K_HANG:       return "R9";
      default:      return v.late ? "R7" : "R3";
    endcase
  endfunction

  task automatic run_vec(input vec_t v);
    int n;
    bit got, trap;
    logic [15:0] rd, exp_w;
    string t;
    t = tag_of(v);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    #1;
    cur = v; attempt = 0; as_falls = 0; retries = 0; hold = 0; in_cyc = 0;
    addr_bad = 0; ds_first = 0; overlap = 0; early_ready = 0;
    hang_seen = 0; hang_as_bad = 0; lanes_seen = '0; cap_data = '0;
    late_verify_i = v.late;
    req_addr_i = full_addr(v.addr); req_write_i = v.wr; req_be_i = v.be;
    req_fc_i = v.fc; req_wdata_i = v.wdata; req_valid_i = 1'b1;
    @(posedge clk_i);
    n = 0; got = 0; trap = 0; rd = '0;
    while (!got && n < 400) begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
      if (rsp_done_o || rsp_berr_o) begin
        got = 1; trap = rsp_berr_o; rd = rsp_rdata_o;
        chk(bus_as_no && bus_uds_no && bus_lds_no, "R8", "strobes at outcome",
            {bus_as_no, bus_uds_no, bus_lds_no}, 3'b111);
      end else n++;
    end
    while (!req_ready_o) @(negedge clk_i);
    chk(got && trap == v.res, t, "outcome trap", int'(trap), int'(v.res));
    if (v.lat != 0) chk(n == int'(v.lat), t, "outcome edge", n, int'(v.lat));
    if (!v.wr && !v.res)
      chk(rd == {v.addr, ~v.addr}, "R4", "read data", rd, {v.addr, ~v.addr});
    if (v.wr) begin
      exp_w = {v.be[1] ? v.wdata[15:8] : 8'h00, v.be[0] ? v.wdata[7:0] : 8'h00};
      chk(cap_data == exp_w, "R2", "write lanes data", cap_data, exp_w);
    end
    chk(lanes_seen == v.be, "R2", "lanes strobed", lanes_seen, v.be);
    chk(ds_first == !v.wr, "R2", "data strobe with address strobe", ds_first, !v.wr);
    chk(!addr_bad, "R2", "address/rw/fc at strobe", addr_bad, 0);
    chk(retries == int'(v.retry), "R6", "retry pulses", retries, int'(v.retry));
    chk(as_falls == int'(v.retry) + 1, "R6", "bus attempts", as_falls, int'(v.retry) + 1);
    chk(!overlap && !early_ready, "R8", "start before release", {overlap, early_ready}, 0);
    chk(hang_seen == (v.kind == K_HANG), "R9", "hang flag", hang_seen, v.kind == K_HANG);
    chk(!hang_as_bad, "R9", "strobe held under hang", hang_as_bad, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cur = VECS[0];
    attempt = 0; hold = 0; in_cyc = 0; as_falls = 0; retries = 0;
    repeat (2) @(negedge clk_i);
    chk(bus_as_no && bus_uds_no && bus_lds_no && bus_rw_o && !bus_data_oe_o, "R1",
        "bus idle in reset", {bus_as_no, bus_uds_no, bus_lds_no, bus_rw_o, bus_data_oe_o},
        5'b11110);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(bus_as_no && bus_uds_no && bus_lds_no && bus_rw_o && !bus_data_oe_o, "R1",
        "bus idle after reset", {bus_as_no, bus_uds_no, bus_lds_no, bus_rw_o, bus_data_oe_o},
        5'b11110);
    chk(req_ready_o, "R1", "ready", req_ready_o, 1);
    chk(!rsp_done_o && !rsp_berr_o && !rsp_retry_o && !hang_o, "R1", "no pulses",
        {rsp_done_o, rsp_berr_o, rsp_retry_o, hang_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // directed: slave never acknowledges until well past the timeout
    run_vec(HANG_VEC);
    // directed: a plain read after the long wait behaves normally again
    run_vec(VECS[0]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule